// File: doc/BRIEF.md
# Time-Slotted Synchronous Serial Port

This block moves words between parallel word registers and serial data pins, timed by a bit-clock strobe and a frame-sync pulse. Both arrive as single-cycle qualifiers in the system clock domain. It has one receive engine and a parameterised number of transmit lanes, three by default. Each engine can be enabled on its own. The frame sync lasts one bit period and is seen one bit before the most significant bit of the first slot. Words are 8, 16 or 24 bits long and are shifted most significant bit first.

In normal mode a frame carries a single word, in slot 0. In network mode a frame is cut into up to 32 time slots. A slot mask for each direction picks which slots a transmitter drives and which slots the receiver keeps. In shared-clock mode, the receiver and every transmit lane follow the receive strobe and sync. In split-clock mode, lane 0 follows its own transmit strobe and sync, and all other lanes are held off the line.

Software-side traffic uses a one-word holding register per transmit lane, with an empty flag, and one received-word register with a full flag and the index of the slot it came from. Underrun and overrun are reported by sticky flags.

Top module: `tdm_sync_port`

## Requirements
- R1: After reset every transmit lane reports empty, no lane drives (output enable low), the receive register is not full, and both error flags are clear.
- R2: The word_len code selects the word length: 0 gives 8 bits, 1 gives 16 bits, 2 and 3 give 24 bits. Transmit words are taken from the low bits of tx_wdata. Received words appear right-justified on rx_rdata with the unused upper bits zero. Bits move most significant first.
- R3: A frame sync sampled on a strobe starts a frame. The most significant bit of slot 0 is driven after that strobe and sampled on the following strobe. Between strobes the serial output of an enabled lane does not change.
- R4: With net_mode high, bit n of rx_mask keeps slot n, and rx_slot gives the index of the delivered word. With net_mode low, only slot 0 is moved, once per frame.
- R5: A transmit lane drives (tx_oe high) only during slots it owns: slot 0 in normal mode, or slots whose bit is set in tx_mask in network mode. Outside those slots its output enable is low.
- R6: With sync_mode high, every transmit lane uses the receive strobe and sync, and all three lanes can drive the same slot at once.
- R7: With sync_mode low, lane 0 is timed only by tx_bclk_en and tx_fs, and lanes 1 and up keep tx_oe low whatever their enables are.
- R8: If a lane has to send a word while its holding register is empty, it sends its previous word again and sets tx_underrun. The next write to that lane clears the flag.
- R9: If a word completes while rx_full is still set, the new word replaces the old one and rx_overrun is set. A read clears rx_overrun.
- R10: A disabled receiver never raises rx_full, and a disabled transmit lane keeps tx_oe low.
- R11: A write clears the lane's empty flag, and loading the word into the shifter sets it again. A completed enabled slot sets rx_full, and a read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_mode | input | 1 | 1: transmit lanes share the receive timing; 0: split timing |
| net_mode | input | 1 | 1: slotted frames; 0: one word per frame |
| word_len | input | 2 | Word length code (see R2) |
| rx_en | input | 1 | Receive engine enable |
| tx_en | input | NUM_TX | Per-lane transmit enable |
| rx_mask | input | NSLOT | Receive slot selection |
| tx_mask | input | NSLOT | Transmit slot selection |
| rx_bclk_en | input | 1 | Receive bit strobe |
| rx_fs | input | 1 | Receive frame sync |
| tx_bclk_en | input | 1 | Transmit bit strobe (split mode) |
| tx_fs | input | 1 | Transmit frame sync (split mode) |
| rx_sd | input | 1 | Serial receive data |
| rx_rd | input | 1 | Read pulse for the received word |
| rx_rdata | output | DW | Received word |
| rx_slot | output | SW | Slot index of the received word |
| rx_full | output | 1 | Received word waiting |
| rx_overrun | output | 1 | Sticky overrun flag |
| tx_wr | input | NUM_TX | Per-lane write pulse |
| tx_wdata | input | NUM_TX*DW | Per-lane write data, lane i in bits i*DW upward |
| tx_empty | output | NUM_TX | Per-lane holding register empty |
| tx_underrun | output | NUM_TX | Per-lane sticky underrun flag |
| tx_sd | output | NUM_TX | Serial transmit data |
| tx_oe | output | NUM_TX | Per-lane drive enable; low means high-impedance |

## Verification
Some properties are checked on every cycle: a disabled lane stops driving, the serial output holds steady between strobes, the error flags rise only under their causes, rx_full rises only on a receive strobe, and lanes 1 and up stay silent in split mode. Other behaviour can only be shown by scenarios at the pins: that the bits arrive in the right order and the right slot, that the mask picks the right slots, that the repeated word is correct after an underrun, that an overwrite keeps the newer word, and that split-mode transmission runs while the receive clock is stopped. The bench loops transmit lanes back to the receiver to show these.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
    localparam int MAXW = 24;

    typedef enum logic [1:0] {
        WL_8   = 2'd0,
        WL_16  = 2'd1,
        WL_24  = 2'd2,
        WL_24X = 2'd3
    } wlen_e;

    function automatic logic [5:0] wl_bits(wlen_e w);
        case (w)
            WL_8:    return 6'd8;
            WL_16:   return 6'd16;
            default: return 6'd24;
        endcase
    endfunction
endpackage

// File: rtl/tsp_clk_route.sv
module tsp_clk_route #(
    parameter int NUM_TX = 3
) (
    input  logic              sync_mode,
    input  logic              rx_bclk_en,
    input  logic              rx_fs,
    input  logic              tx_bclk_en,
    input  logic              tx_fs,
    input  logic [NUM_TX-1:0] tx_en,
    output logic              lane_bclk,
    output logic              lane_fs,
    output logic [NUM_TX-1:0] lane_en
);
    assign lane_bclk = sync_mode ? rx_bclk_en : tx_bclk_en;
    assign lane_fs   = sync_mode ? rx_fs      : tx_fs;

    for (genvar i = 0; i < NUM_TX; i++) begin : g_en
        if (i == 0) begin : g_first
            assign lane_en[i] = tx_en[i];
        end else begin : g_rest
            // extra lanes only exist when timing is shared
            assign lane_en[i] = tx_en[i] & sync_mode;
        end
    end
endmodule

// File: rtl/tsp_tx_lane.sv
module tsp_tx_lane
    import tsp_pkg::*;
#(
    parameter int DW    = MAXW,
    parameter int NSLOT = 32,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int BW   = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bclk_en,
    input  logic             fs,
    input  logic             net_mode,
    input  wlen_e            wl,
    input  logic [NSLOT-1:0] mask,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    output logic             empty,
    output logic             underrun,
    output logic             sd,
    output logic             oe
);
    typedef struct packed {
        logic          active;
        logic [BW-1:0] bitc;
        logic [SW-1:0] slot;
        logic [DW-1:0] shreg;
        logic [DW-1:0] hold;
        logic          full;
        logic [DW-1:0] last;
        logic          urun;
        logic          sd;
        logic          oe;
    } tx_st_t;

    tx_st_t q, d;

    logic [5:0]    wlen;
    logic          load_req;
    logic [SW-1:0] load_slot;
    logic          slot_on;
    logic          new_urun;
    logic [DW-1:0] word;
    logic [DW-1:0] just;

    assign wlen = wl_bits(wl);

    always_comb begin
        d         = q;
        load_req  = 1'b0;
        load_slot = '0;
        slot_on   = 1'b0;
        new_urun  = 1'b0;
        word      = q.last;
        just      = '0;

        if (!en) begin
            d.active = 1'b0;
            d.oe     = 1'b0;
            d.sd     = 1'b0;
        end else if (bclk_en) begin
            if (fs) begin
                d.active  = 1'b1;
                d.bitc    = '0;
                d.slot    = '0;
                load_req  = 1'b1;
                load_slot = '0;
            end else if (q.active) begin
                if (q.bitc == BW'(wlen - 6'd1)) begin
                    d.bitc = '0;
                    if (!net_mode || q.slot == SW'(NSLOT - 1)) begin
                        d.active = 1'b0;
                        d.oe     = 1'b0;
                        d.sd     = 1'b0;
                    end else begin
                        d.slot    = q.slot + 1'b1;
                        load_req  = 1'b1;
                        load_slot = q.slot + 1'b1;
                    end
                end else begin
                    d.bitc  = q.bitc + 1'b1;
                    d.shreg = q.shreg << 1;
                    d.sd    = q.oe ? q.shreg[DW-2] : 1'b0;
                end
            end
        end

        if (load_req) begin
            slot_on = net_mode ? mask[load_slot] : 1'b1;
            if (slot_on) begin
                if (q.full) begin
                    word   = q.hold;
                    d.full = 1'b0;
                end else begin
                    word     = q.last;
                    new_urun = 1'b1;
                end
                just    = word << (DW - int'(wlen));
                d.last  = word;
                d.shreg = just;
                d.sd    = just[DW-1];
                d.oe    = 1'b1;
            end else begin
                d.shreg = '0;
                d.sd    = 1'b0;
                d.oe    = 1'b0;
            end
        end

        if (wr) begin
            d.hold = wdata;
            d.full = 1'b1;
        end
        d.urun = (q.urun & ~wr) | new_urun;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign empty    = ~q.full;
    assign underrun = q.urun;
    assign sd       = q.sd;
    assign oe       = q.oe;

    // R10
    tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !oe);

    // R8
    urun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.urun) |-> !$past(q.full));

    // R3
    sd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bclk_en) |=> $stable(sd));
endmodule

// File: rtl/tsp_rx_lane.sv
module tsp_rx_lane
    import tsp_pkg::*;
#(
    parameter int DW    = MAXW,
    parameter int NSLOT = 32,
    localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int BW   = $clog2(DW + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             bclk_en,
    input  logic             fs,
    input  logic             net_mode,
    input  wlen_e            wl,
    input  logic [NSLOT-1:0] mask,
    input  logic             sd,
    input  logic             rd,
    output logic [DW-1:0]    rdata,
    output logic [SW-1:0]    rslot,
    output logic             full,
    output logic             overrun
);
    typedef struct packed {
        logic          active;
        logic [BW-1:0] bitc;
        logic [SW-1:0] slot;
        logic [DW-1:0] shreg;
        logic [DW-1:0] data;
        logic [SW-1:0] rslot;
        logic          full;
        logic          ovr;
    } rx_st_t;

    rx_st_t q, d;

    logic [5:0]  wlen;
    logic [DW:0] keep;
    logic        slot_on;

    assign wlen = wl_bits(wl);
    assign keep = ((DW + 1)'(1) << wlen) - (DW + 1)'(1);

    always_comb begin
        d       = q;
        slot_on = 1'b0;

        if (rd) begin
            d.full = 1'b0;
            d.ovr  = 1'b0;
        end

        if (!en) begin
            d.active = 1'b0;
        end else if (bclk_en) begin
            if (fs) begin
                d.active = 1'b1;
                d.bitc   = '0;
                d.slot   = '0;
            end else if (q.active) begin
                d.shreg = {q.shreg[DW-2:0], sd};
                if (q.bitc == BW'(wlen - 6'd1)) begin
                    slot_on = net_mode ? mask[q.slot] : 1'b1;
                    if (slot_on) begin
                        d.data  = d.shreg & keep[DW-1:0];
                        d.rslot = q.slot;
                        d.full  = 1'b1;
                        if (q.full && !rd) d.ovr = 1'b1;
                    end
                    d.bitc = '0;
                    if (!net_mode || q.slot == SW'(NSLOT - 1)) d.active = 1'b0;
                    else                                       d.slot   = q.slot + 1'b1;
                end else begin
                    d.bitc = q.bitc + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata   = q.data;
    assign rslot   = q.rslot;
    assign full    = q.full;
    assign overrun = q.ovr;

    // R9
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovr) |-> $past(q.full));

    // R11
    full_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.full) |-> ($past(bclk_en) && $past(en)));

    // R10
    rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !full) |=> !full);
endmodule

// File: rtl/tdm_sync_port.sv
module tdm_sync_port
    import tsp_pkg::*;
#(
    parameter int NUM_TX = 3,
    parameter int NSLOT  = 32,
    parameter int DW     = MAXW,
    localparam int SW    = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sync_mode,
    input  logic                 net_mode,
    input  logic [1:0]           word_len,
    input  logic                 rx_en,
    input  logic [NUM_TX-1:0]    tx_en,
    input  logic [NSLOT-1:0]     rx_mask,
    input  logic [NSLOT-1:0]     tx_mask,
    input  logic                 rx_bclk_en,
    input  logic                 rx_fs,
    input  logic                 tx_bclk_en,
    input  logic                 tx_fs,
    input  logic                 rx_sd,
    input  logic                 rx_rd,
    output logic [DW-1:0]        rx_rdata,
    output logic [SW-1:0]        rx_slot,
    output logic                 rx_full,
    output logic                 rx_overrun,
    input  logic [NUM_TX-1:0]    tx_wr,
    input  logic [NUM_TX*DW-1:0] tx_wdata,
    output logic [NUM_TX-1:0]    tx_empty,
    output logic [NUM_TX-1:0]    tx_underrun,
    output logic [NUM_TX-1:0]    tx_sd,
    output logic [NUM_TX-1:0]    tx_oe
);
    wlen_e             wl;
    logic              lane_bclk;
    logic              lane_fs;
    logic [NUM_TX-1:0] lane_en;

    assign wl = wlen_e'(word_len);

    tsp_clk_route #(.NUM_TX(NUM_TX)) u_route (
        .sync_mode  (sync_mode),
        .rx_bclk_en (rx_bclk_en),
        .rx_fs      (rx_fs),
        .tx_bclk_en (tx_bclk_en),
        .tx_fs      (tx_fs),
        .tx_en      (tx_en),
        .lane_bclk  (lane_bclk),
        .lane_fs    (lane_fs),
        .lane_en    (lane_en)
    );

    tsp_rx_lane #(.DW(DW), .NSLOT(NSLOT)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .bclk_en (rx_bclk_en),
        .fs      (rx_fs),
        .net_mode(net_mode),
        .wl      (wl),
        .mask    (rx_mask),
        .sd      (rx_sd),
        .rd      (rx_rd),
        .rdata   (rx_rdata),
        .rslot   (rx_slot),
        .full    (rx_full),
        .overrun (rx_overrun)
    );

    for (genvar i = 0; i < NUM_TX; i++) begin : g_tx
        tsp_tx_lane #(.DW(DW), .NSLOT(NSLOT)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (lane_en[i]),
            .bclk_en (lane_bclk),
            .fs      (lane_fs),
            .net_mode(net_mode),
            .wl      (wl),
            .mask    (tx_mask),
            .wr      (tx_wr[i]),
            .wdata   (tx_wdata[i*DW +: DW]),
            .empty   (tx_empty[i]),
            .underrun(tx_underrun[i]),
            .sd      (tx_sd[i]),
            .oe      (tx_oe[i])
        );

        if (i > 0) begin : g_split_chk
            // R7
            split_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !sync_mode |=> !tx_oe[i]);
        end
    end
endmodule

// File: tb/sim_tdm_sync_port.sv
module sim_tdm_sync_port;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_TX = 3;
    localparam int NSLOT  = 32;
    localparam int DW     = 24;
    localparam int SW     = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_mode = 1'b1, net_mode = 1'b0;
    logic [1:0] word_len = 2'd0;
    logic rx_en = 1'b1;
    logic [NUM_TX-1:0] tx_en = 3'b001;
    logic [NSLOT-1:0] rx_mask = '0, tx_mask = '0;
    logic rx_bclk_en = 1'b0, rx_fs = 1'b0, tx_bclk_en = 1'b0, tx_fs = 1'b0;
    logic rx_sd;
    logic rx_rd = 1'b0;
    logic [DW-1:0] rx_rdata;
    logic [SW-1:0] rx_slot;
    logic rx_full, rx_overrun;
    logic [NUM_TX-1:0] tx_wr = '0;
    logic [NUM_TX*DW-1:0] tx_wdata = '0;
    logic [NUM_TX-1:0] tx_empty, tx_underrun, tx_sd, tx_oe;
    int lb = 0;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign rx_sd = tx_oe[lb] ? tx_sd[lb] : 1'b0;

    tdm_sync_port #(.NUM_TX(NUM_TX), .NSLOT(NSLOT), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .net_mode(net_mode),
        .word_len(word_len), .rx_en(rx_en), .tx_en(tx_en), .rx_mask(rx_mask),
        .tx_mask(tx_mask), .rx_bclk_en(rx_bclk_en), .rx_fs(rx_fs),
        .tx_bclk_en(tx_bclk_en), .tx_fs(tx_fs), .rx_sd(rx_sd), .rx_rd(rx_rd),
        .rx_rdata(rx_rdata), .rx_slot(rx_slot), .rx_full(rx_full),
        .rx_overrun(rx_overrun), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
        .tx_empty(tx_empty), .tx_underrun(tx_underrun), .tx_sd(tx_sd), .tx_oe(tx_oe)
    );

    // word_len code in [25:24], data in [23:0]
    localparam logic [25:0] VEC [0:7] = '{
        26'h0FFFF3C, 26'h0000081, 26'h1AB1234, 26'h100F00F,
        26'h2C0FFEE, 26'h2800001, 26'h35A5A5A, 26'h3123456
    };

    function automatic int nbits(logic [1:0] c);
        return (c == 2'd0) ? 8 : (c == 2'd1) ? 16 : 24;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick_rx(input logic f);
        @(negedge clk); rx_bclk_en = 1'b1; rx_fs = f;
        @(negedge clk); rx_bclk_en = 1'b0; rx_fs = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick_tx(input logic f);
        @(negedge clk); tx_bclk_en = 1'b1; tx_fs = f;
        @(negedge clk); tx_bclk_en = 1'b0; tx_fs = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick_rx(1'b0);
    endtask

    task automatic put(input int lane, input logic [DW-1:0] w);
        @(negedge clk); tx_wr[lane] = 1'b1; tx_wdata[lane*DW +: DW] = w;
        @(negedge clk); tx_wr = '0;
    endtask

    task automatic take();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] cap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 empty", 32'(tx_empty), 32'h7);
        chk("R1 oe", 32'(tx_oe), 32'h0);
        chk("R1 full", 32'(rx_full), 32'h0);
        chk("R1 flags", {30'h0, rx_overrun, |tx_underrun}, 32'h0);

        // R2 / R3 / R11: normal-mode loopback over the vector table
        for (int v = 0; v < 8; v++) begin
            logic [23:0] m;
            word_len = VEC[v][25:24];
            m = 24'((32'h1 << nbits(word_len)) - 1);
            put(0, VEC[v][23:0]);
            chk("R11 wr clears empty", 32'(tx_empty[0]), 32'h0);
            tick_rx(1'b1);
            chk("R11 load sets empty", 32'(tx_empty[0]), 32'h1);
            ticks(nbits(word_len));
            chk("R2 word", 32'(rx_rdata), 32'(VEC[v][23:0] & m));
            chk("R3 slot0 full", {31'h0, rx_full}, 32'h1);
            take();
            chk("R11 rd clears full", {31'h0, rx_full}, 32'h0);
        end

        // R4 / R5: network mode, slots 1 and 3
        net_mode = 1'b1; word_len = 2'd0;
        tx_mask = 32'h0000_000A; rx_mask = 32'h0000_000A;
        put(0, 24'h00005A);
        tick_rx(1'b1);
        ticks(4);
        chk("R5 slot0 idle", 32'(tx_oe[0]), 32'h0);
        ticks(4);
        chk("R5 slot1 drive", 32'(tx_oe[0]), 32'h1);
        put(0, 24'h0000C3);
        ticks(8);
        chk("R4 slot1 data", 32'(rx_rdata), 32'h5A);
        chk("R4 slot1 index", 32'(rx_slot), 32'd1);
        chk("R5 slot2 idle", 32'(tx_oe[0]), 32'h0);
        take();
        ticks(8);
        chk("R4 slot2 skipped", {31'h0, rx_full}, 32'h0);
        ticks(8);
        chk("R4 slot3 data", 32'(rx_rdata), 32'hC3);
        chk("R4 slot3 index", 32'(rx_slot), 32'd3);
        take();

        // R8: underrun repeats previous word
        net_mode = 1'b0;
        tick_rx(1'b1);
        ticks(8);
        chk("R8 flag", 32'(tx_underrun[0]), 32'h1);
        chk("R8 repeat", 32'(rx_rdata), 32'hC3);
        take();
        put(0, 24'h000011);
        chk("R8 cleared by write", 32'(tx_underrun[0]), 32'h0);

        // R9: overrun overwrites
        tick_rx(1'b1); ticks(8);
        put(0, 24'h000022);
        tick_rx(1'b1); ticks(8);
        chk("R9 flag", {31'h0, rx_overrun}, 32'h1);
        chk("R9 newest", 32'(rx_rdata), 32'h22);
        take();
        chk("R9 cleared by read", {31'h0, rx_overrun}, 32'h0);

        // R6: three lanes in shared timing
        tx_en = 3'b111; word_len = 2'd1; lb = 2;
        put(0, 24'h001111); put(1, 24'h002222); put(2, 24'h00BEAD);
        tick_rx(1'b1); ticks(5);
        chk("R6 all drive", 32'(tx_oe), 32'h7);
        ticks(11);
        chk("R6 lane2 word", 32'(rx_rdata), 32'hBEAD);
        take();

        // R7: split timing, lane 0 only, own strobe
        sync_mode = 1'b0; lb = 0;
        put(0, 24'h00BEEF); put(1, 24'h001234);
        tick_tx(1'b1);
        cap = {15'h0, tx_sd[0]};
        for (int k = 1; k < 16; k++) begin
            if (k == 3) chk("R7 only lane0", 32'(tx_oe), 32'h1);
            tick_tx(1'b0);
            cap = {cap[14:0], tx_sd[0]};
        end
        chk("R7 serial bits", 32'(cap), 32'hBEEF);
        chk("R7 rx clock idle", {31'h0, rx_full}, 32'h0);
        sync_mode = 1'b1;

        // R10: disabled engines
        word_len = 2'd0; rx_en = 1'b0;
        put(0, 24'h000077);
        tick_rx(1'b1); ticks(8);
        chk("R10 rx off", {31'h0, rx_full}, 32'h0);
        rx_en = 1'b1; tx_en = 3'b000;
        put(0, 24'h000066);
        tick_rx(1'b1); ticks(3);
        chk("R10 tx off", 32'(tx_oe), 32'h0);
        ticks(5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule